// File: doc/BRIEF.md
# Timer Overflow Status and Interrupt Register

This block is the 8-bit status and control register that sits beside a three-channel 16-bit timer. It keeps one sticky flag per channel that remembers a counter wrap. It also holds one enable bit that gates a level interrupt request from channel 0. The counters are outside the block. Each one reports a wrap as a single-cycle pulse on `cnt_wrap`. Channel 2 can count in both directions: `ch2_down` gives its direction, and `phase_mode` says whether it is in phase counting mode.

A flag can only be cleared on purpose. The CPU must first read the register while that flag is 1, which arms the flag. It must then write 0 to that bit. Each flag is a small state machine with three states:

- `FLAG_CLEAR`: the flag is 0.
- `FLAG_PENDING`: the flag is 1 and no read has seen it yet.
- `FLAG_ARMED`: the flag is 1 and a read has seen it.

The named transitions are:

- **set**: CLEAR to PENDING, on a qualified wrap event.
- **arm**: PENDING to ARMED, on a read without a write.
- **clear**: ARMED to CLEAR, on a write of 0 with no event in the same cycle.
- **consume**: ARMED to PENDING, on any other write.

All other cases hold the current state. The bus has no address because the block has only one register. The read data is combinational from the stored state.

Top module: `tmr_ovf_stat`

## Requirements
- R1: After reset, `rdata` is 0x08 and `irq` is 0.
- R2: A pulse on `cnt_wrap[i]` (with `ch2_down`=0 for channel 2) sets bit i of `rdata` (bit 0 = channel 0, bit 1 = channel 1, bit 2 = channel 2) on the next clock edge. The bit stays 1 until it is cleared by R4.
- R3: A channel-2 wrap with `ch2_down`=1 is an underflow. It sets bit 2 only when `phase_mode`=1. When `phase_mode`=0 it leaves bit 2 at 0.
- R4: A write of 0 to a set flag bit clears it only if an earlier read (`bus_rd`=1, `bus_wr`=0) returned that bit as 1. A write of 0 without such a read leaves the bit at 1.
- R5: Any write disarms every flag. After an arming read, a write with the bit at 1 keeps the flag set. A later write of 0 then does not clear it.
- R6: Writing 1 to a flag bit that is 0 never sets it.
- R7: If a wrap event for a flag comes in the same cycle as a write that would clear it, the flag stays 1 and is left unarmed.
- R8: Bit 4 is the channel-0 interrupt enable. Every write loads it from `bus_wdata[4]`, it reads back unchanged, and it is 0 after reset.
- R9: `irq` is registered. In each cycle it equals (bit 0 AND bit 4) as they were one clock earlier.
- R10: Bit 3 always reads 1 and bits 7 to 5 always read 0. Writes to these bits have no effect.
- R11: A cycle with both `bus_rd` and `bus_wr` is treated as a write. The write uses the arming from earlier reads, and the read in that cycle arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wrap | input | 3 | Per-channel counter wrap pulse |
| ch2_down | input | 1 | Channel 2 direction, 1 = counting down |
| phase_mode | input | 1 | Channel 2 phase counting mode |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| rdata | output | 8 | Register read value |
| irq | output | 1 | Channel-0 overflow interrupt request |

## Verification
The assertions check the following on every cycle:

- Flags are sticky after a qualified event.
- No flag rises without an event.
- An underflow is masked outside phase counting mode.
- The reserved bits hold their fixed values.
- The interrupt follows flag 0 AND enable with a one-cycle lag.
- A flag falls only from the armed state.

Only the bench scenarios can show the full clear handshake, because it spans several cycles. These scenarios cover:

- the read-then-write-0 sequence;
- a write that disarms without clearing;
- an event that wins over a clearing write;
- a combined read-and-write cycle that must not arm.

// File: rtl/tmr_ovf_pkg.sv
package tmr_ovf_pkg;
    localparam int NUM_CH      = 3;
    localparam int REG_W       = 8;
    localparam int ENABLE_POS  = 4;
    localparam int RSVD_POS    = 3;
    localparam int BIDIR_CH    = 2;

    typedef enum logic [1:0] {
        FLAG_CLEAR   = 2'd0,
        FLAG_PENDING = 2'd1,
        FLAG_ARMED   = 2'd2
    } flag_state_e;
endpackage

// File: rtl/ovf_event_qual.sv
module ovf_event_qual #(
    parameter int NCH     = 3,
    parameter int DIR_CH  = 2
) (
    input  logic [NCH-1:0] wrap_i,
    input  logic           down_i,
    input  logic           phase_i,
    output logic [NCH-1:0] set_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == DIR_CH) begin : g_bidir
            // upward wrap always counts; downward wrap only in phase counting mode
            assign set_o[g] = wrap_i[g] & (~down_i | phase_i);
        end else begin : g_up
            assign set_o[g] = wrap_i[g];
        end
    end
endmodule

// File: rtl/ovf_flag_fsm.sv
module ovf_flag_fsm
    import tmr_ovf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (set_i) state_d = FLAG_PENDING;              // set
            end
            FLAG_PENDING: begin
                if (rd_i && !wr_i) state_d = FLAG_ARMED;        // arm
            end
            FLAG_ARMED: begin
                if (wr_i) begin
                    if (!wbit_i && !set_i) state_d = FLAG_CLEAR;   // clear
                    else                   state_d = FLAG_PENDING; // consume
                end
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q != FLAG_CLEAR);
    end

    // R2 / R7: an accepted event always leaves the flag set
    a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R6: nothing but an event raises a cleared flag
    a_r6_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i) |=> !flag_o);

    // R4: a flag can only fall from the armed state
    a_r4_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && state_q != FLAG_ARMED) |=> flag_o);

    // R11: a combined read/write never arms
    a_r11_rdwr_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLAG_PENDING && wr_i) |=> state_q == FLAG_PENDING);
endmodule

// File: rtl/tmr_ovf_stat.sv
module tmr_ovf_stat
    import tmr_ovf_pkg::*;
#(
    parameter int NCH     = NUM_CH,
    parameter int W       = REG_W,
    parameter int EN_BIT  = ENABLE_POS,
    parameter int RSV_BIT = RSVD_POS,
    parameter int DIR_CH  = BIDIR_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cnt_wrap,
    input  logic           ch2_down,
    input  logic           phase_mode,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   rdata,
    output logic           irq
);
    localparam int HI_LSB = EN_BIT + 1;

    logic [NCH-1:0] set_ev;
    logic [NCH-1:0] flag;
    logic           en_q;
    logic           irq_q;

    ovf_event_qual #(.NCH(NCH), .DIR_CH(DIR_CH)) u_qual (
        .wrap_i  (cnt_wrap),
        .down_i  (ch2_down),
        .phase_i (phase_mode),
        .set_o   (set_ev)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_flag
        ovf_flag_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_ev[g]),
            .rd_i   (bus_rd),
            .wr_i   (bus_wr),
            .wbit_i (bus_wdata[g]),
            .flag_o (flag[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (bus_wr) en_q <= bus_wdata[EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= flag[0] & en_q;
    end

    always_comb begin
        rdata          = '0;
        rdata[NCH-1:0] = flag;
        rdata[RSV_BIT] = 1'b1;
        rdata[EN_BIT]  = en_q;
        irq            = irq_q;
    end

    // R9: request lags flag0 AND enable by one cycle
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(rdata[0] & rdata[EN_BIT]));

    // R10: fixed bits never move, whatever is written
    a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_wdata[W-1:HI_LSB] != '0 || !bus_wdata[RSV_BIT]))
        |=> (rdata[W-1:HI_LSB] == '0 && rdata[RSV_BIT]));

    // R3: underflow outside phase counting mode is masked
    a_r3_underflow_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wrap[DIR_CH] && ch2_down && !phase_mode && !rdata[DIR_CH])
        |=> !rdata[DIR_CH]);

    // R8: enable follows the written bit
    a_r8_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> rdata[EN_BIT] == $past(bus_wdata[EN_BIT]));
endmodule

// File: tb/tmr_ovf_stat_tb.sv
module tmr_ovf_stat_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cnt_wrap = '0;
    logic       ch2_down = 1'b0;
    logic       phase_mode = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    tmr_ovf_stat u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_wrap(cnt_wrap), .ch2_down(ch2_down),
        .phase_mode(phase_mode), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus/event cycle; rv is the read data seen during the cycle
    task automatic cyc(input logic rd, input logic wr, input logic [7:0] wd,
                       input logic [2:0] wrap, input logic down, output logic [7:0] rv);
        bus_rd = rd; bus_wr = wr; bus_wdata = wd; cnt_wrap = wrap; ch2_down = down;
        #1 rv = rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0; cnt_wrap = '0; ch2_down = 1'b0;
    endtask

    task automatic idle();
        logic [7:0] v;
        cyc(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, v);
    endtask

    task automatic pulse(input logic [2:0] m, input logic down);
        logic [7:0] v;
        cyc(1'b0, 1'b0, 8'h00, m, down, v);
    endtask

    task automatic wr(input logic [7:0] d);
        logic [7:0] v;
        cyc(1'b0, 1'b1, d, 3'b000, 1'b0, v);
    endtask

    task automatic rd_cpu(output logic [7:0] v);
        cyc(1'b1, 1'b0, 8'h00, 3'b000, 1'b0, v);
    endtask

    task automatic t_reset();
        check("R1 reset rdata", rdata, 8'h08);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        check("R8 reset enable", {7'b0, rdata[4]}, 8'h00);
    endtask

    task automatic t_set_and_clear();
        logic [7:0] v;
        pulse(3'b001, 1'b0);
        check("R2 ch0 set", rdata, 8'h09);
        pulse(3'b010, 1'b0);
        check("R2 ch1 set sticky", rdata, 8'h0B);
        wr(8'h00);
        check("R4 write0 without read", rdata, 8'h0B);
        rd_cpu(v);
        check("R4 read sees flags", v, 8'h0B);
        wr(8'h00);
        check("R4 read then write0 clears", rdata, 8'h08);
    endtask

    task automatic t_consume();
        logic [7:0] v;
        pulse(3'b001, 1'b0);
        rd_cpu(v);
        wr(8'h01);
        check("R5 write1 keeps flag", rdata, 8'h09);
        wr(8'h00);
        check("R5 arm consumed", rdata, 8'h09);
        rd_cpu(v);
        wr(8'h00);
        check("R5 rearm clears", rdata, 8'h08);
    endtask

    task automatic t_sw_set();
        wr(8'hFF);
        check("R6 R10 R8 write FF", rdata, 8'h18);
        wr(8'hE0);
        check("R10 high bits ignored", rdata, 8'h08);
    endtask

    task automatic t_ch2();
        logic [7:0] v;
        phase_mode = 1'b0;
        pulse(3'b100, 1'b1);
        check("R3 underflow masked mode0", rdata, 8'h08);
        pulse(3'b100, 1'b0);
        check("R2 ch2 overflow mode0", rdata, 8'h0C);
        rd_cpu(v);
        wr(8'h00);
        check("R4 ch2 clear", rdata, 8'h08);
        phase_mode = 1'b1;
        pulse(3'b100, 1'b1);
        check("R3 underflow in phase mode", rdata, 8'h0C);
        rd_cpu(v);
        wr(8'h00);
        phase_mode = 1'b0;
        check("R4 ch2 clear again", rdata, 8'h08);
    endtask

    task automatic t_race();
        logic [7:0] v;
        pulse(3'b001, 1'b0);
        rd_cpu(v);
        cyc(1'b0, 1'b1, 8'h00, 3'b001, 1'b0, v);
        check("R7 set wins over clear", rdata, 8'h09);
        wr(8'h00);
        check("R7 left unarmed", rdata, 8'h09);
        rd_cpu(v);
        wr(8'h00);
        check("R7 cleanup", rdata, 8'h08);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(8'h10);
        check("R8 enable set", rdata, 8'h18);
        pulse(3'b001, 1'b0);
        check("R9 flag set", rdata, 8'h19);
        check("R9 irq lags", {7'b0, irq}, 8'h00);
        idle();
        check("R9 irq raised", {7'b0, irq}, 8'h01);
        wr(8'h01);
        check("R9 disable flag kept", rdata, 8'h09);
        check("R9 irq still high", {7'b0, irq}, 8'h01);
        idle();
        check("R9 irq masked", {7'b0, irq}, 8'h00);
        rd_cpu(v);
        wr(8'h00);
        check("R9 cleanup", rdata, 8'h08);
    endtask

    task automatic t_rdwr();
        logic [7:0] v;
        pulse(3'b010, 1'b0);
        cyc(1'b1, 1'b1, 8'h00, 3'b000, 1'b0, v);
        check("R11 rdwr no clear", rdata, 8'h0A);
        wr(8'h00);
        check("R11 rdwr did not arm", rdata, 8'h0A);
        rd_cpu(v);
        wr(8'h00);
        check("R11 cleanup", rdata, 8'h08);
    endtask

    initial begin
        #2000000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_and_clear();
        t_consume();
        t_sw_set();
        t_ch2();
        t_race();
        t_irq();
        t_rdwr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule